// File: doc/BRIEF.md
# Script Register-Operation ALU Unit

This unit executes one register-manipulation instruction of a small script-driven I/O sequencer. A decoded 32-bit first instruction word arrives with a one-cycle start strobe. The unit reads a one-byte operand from a 128-entry byte register file or from a dedicated pivot byte register. It combines that operand with either an immediate byte or the live pivot value in an eight-operation ALU, and writes the one-byte result to the destination that the instruction form selects.

The same unit also runs the flag set and flag clear instructions. These act on four control flags: carry, target mode, ACK and ATN. The flags are plain registers driven straight onto outputs. Every accepted instruction ends with a single-cycle done pulse. A synchronous read port lets the surrounding sequencer observe any byte of the register file.

Top module: `scr_regop_unit`

## Requirements
- R1: After synchronous reset the pivot byte is 0x00, all four flags are 0 and done is low.
- R2: A start accepted while the unit is idle raises done for exactly one cycle, two clock edges after the edge that sampled start. The result of the instruction is visible while done is high.
- R3: A start seen while an instruction is still executing is ignored. No second done pulse and no second write follow from it.
- R4: When bits 31:27 hold 01111, the unit writes register[bits 22:16] = register[bits 22:16] op operand. The op code sits in bits 26:24: 0 load (the result is the operand), 1 shift left, 2 OR, 3 XOR, 4 AND, 5 shift right, 6 add, 7 add with carry. The immediate operand sits in bits 15:8.
- R5: When bits 31:27 hold 01110, the unit writes pivot = register op operand and leaves the register file unchanged.
- R6: When bits 31:27 hold 01101, the unit writes register = pivot op operand.
- R7: When bit 23 is 1, the pivot byte is used as the operand and the immediate byte is ignored.
- R8: Shift left moves bit 7 into carry and fills bit 0 with 0. Shift right moves bit 0 into carry and fills bit 7 with 0.
- R9: Add writes its carry-out to the carry flag. Add with carry also adds the previous carry flag. Load, OR, XOR and AND leave carry unchanged.
- R10: When bits 31:24 are 0x58, each flag whose bit is 1 is set. When bits 31:24 are 0x60, each such flag is cleared. The flag bits are carry at bit 10, target mode at bit 9, ACK at bit 6 and ATN at bit 3. All other bits have no effect.
- R11: Any other opcode still produces the done pulse but changes no flag, no pivot value and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for one instruction |
| instr_i | input | 32 | First instruction word, sampled with start |
| rd_addr_i | input | 7 | Observation read address |
| rd_data_o | output | 8 | Register byte at rd_addr_i, one cycle later |
| done_o | output | 1 | One-cycle completion pulse |
| pivot_o | output | 8 | Pivot byte register |
| carry_o | output | 1 | Carry flag |
| target_o | output | 1 | Target-mode flag |
| ack_o | output | 1 | ACK flag |
| atn_o | output | 1 | ATN flag |

## Verification
The bench builds the unit with its default widths: an 8-bit datapath and a 7-bit register address. These defaults put the full 32-bit instruction encoding within reach, including the 128-entry file and the 8-bit carry boundary. The tests push add and add-with-carry across 0xFF and drive the shifts out through both end bits. They also cover each of the three routing forms and the pivot-as-operand select. Register contents are observed through the read port after every write, and the flags and pivot through their own outputs.

// File: rtl/scr_regop_pkg.sv
package scr_regop_pkg;
  localparam int INSTR_W = 32;

  localparam logic [4:0] FORM_R_FROM_P = 5'b01101;
  localparam logic [4:0] FORM_P_FROM_R = 5'b01110;
  localparam logic [4:0] FORM_R_FROM_R = 5'b01111;
  localparam logic [7:0] OPC_FLAG_SET = 8'h58;
  localparam logic [7:0] OPC_FLAG_CLR = 8'h60;

  localparam int BIT_CARRY  = 10;
  localparam int BIT_TARGET = 9;
  localparam int BIT_ACK    = 6;
  localparam int BIT_ATN    = 3;
  localparam int BIT_USE_PIVOT = 23;

  typedef enum logic [2:0] {
    ALU_LOAD = 3'd0,
    ALU_SHL  = 3'd1,
    ALU_OR   = 3'd2,
    ALU_XOR  = 3'd3,
    ALU_AND  = 3'd4,
    ALU_SHR  = 3'd5,
    ALU_ADD  = 3'd6,
    ALU_ADDC = 3'd7
  } alu_op_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } exec_st_t;
endpackage

// File: rtl/scr_regop_alu.sv
module scr_regop_alu
  import scr_regop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_t           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] y_o,
  output logic              cout_o,
  output logic              cwr_o
);
  logic [DATA_W:0] sum;

  always_comb begin
    sum    = '0;
    y_o    = '0;
    cout_o = 1'b0;
    cwr_o  = 1'b0;
    unique case (op_i)
      ALU_LOAD: y_o = b_i;
      ALU_SHL: begin
        y_o    = {a_i[DATA_W-2:0], 1'b0};
        cout_o = a_i[DATA_W-1];
        cwr_o  = 1'b1;
      end
      ALU_OR:  y_o = a_i | b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_SHR: begin
        y_o    = {1'b0, a_i[DATA_W-1:1]};
        cout_o = a_i[0];
        cwr_o  = 1'b1;
      end
      ALU_ADD, ALU_ADDC: begin
        sum    = {1'b0, a_i} + {1'b0, b_i}
               + {{DATA_W{1'b0}}, (op_i == ALU_ADDC) & cin_i};
        y_o    = sum[DATA_W-1:0];
        cout_o = sum[DATA_W];
        cwr_o  = 1'b1;
      end
      default: y_o = b_i;
    endcase
  end
endmodule

// File: rtl/scr_regop_file.sv
module scr_regop_file #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_a_o <= mem[raddr_a_i];
    rdata_b_o <= mem[raddr_b_i];
  end
endmodule

// File: rtl/scr_regop_unit.sv
module scr_regop_unit
  import scr_regop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 done_o,
  output logic [DATA_W-1:0]    pivot_o,
  output logic                 carry_o,
  output logic                 target_o,
  output logic                 ack_o,
  output logic                 atn_o
);
  localparam int ADDR_LSB = 16;
  localparam int IMM_LSB  = 8;

  exec_st_t           state_q;
  logic [INSTR_W-1:0] instr_q;
  logic [DATA_W-1:0]  reg_val;
  logic [4:0]         form;
  logic [7:0]         opcode;
  logic               is_r_from_p, is_p_from_r, is_r_from_r, is_alu;
  logic [ADDR_W-1:0]  addr;
  logic [DATA_W-1:0]  imm, opnd_a, opnd_b, alu_y;
  logic               alu_cout, alu_cwr, file_we;

  assign form        = instr_q[31:27];
  assign opcode      = instr_q[31:24];
  assign addr        = instr_q[ADDR_LSB +: ADDR_W];
  assign imm         = instr_q[IMM_LSB +: DATA_W];
  assign is_r_from_p = (form == FORM_R_FROM_P);
  assign is_p_from_r = (form == FORM_P_FROM_R);
  assign is_r_from_r = (form == FORM_R_FROM_R);
  assign is_alu      = is_r_from_p | is_p_from_r | is_r_from_r;

  assign opnd_a  = is_r_from_p ? pivot_o : reg_val;
  assign opnd_b  = instr_q[BIT_USE_PIVOT] ? pivot_o : imm;
  assign file_we = (state_q == ST_WRITE) && (is_r_from_p || is_r_from_r);

  scr_regop_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i   (alu_op_t'(instr_q[26:24])),
    .a_i    (opnd_a),
    .b_i    (opnd_b),
    .cin_i  (carry_o),
    .y_o    (alu_y),
    .cout_o (alu_cout),
    .cwr_o  (alu_cwr)
  );

  scr_regop_file #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_file (
    .clk       (clk),
    .we_i      (file_we),
    .waddr_i   (addr),
    .wdata_i   (alu_y),
    .raddr_a_i (addr),
    .rdata_a_o (reg_val),
    .raddr_b_i (rd_addr_i),
    .rdata_b_o (rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      instr_q  <= '0;
      done_o   <= 1'b0;
      pivot_o  <= '0;
      carry_o  <= 1'b0;
      target_o <= 1'b0;
      ack_o    <= 1'b0;
      atn_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          instr_q <= instr_i;
          state_q <= ST_READ;
        end
        ST_READ: state_q <= ST_WRITE;
        ST_WRITE: begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
          if (is_alu) begin
            if (is_p_from_r) pivot_o <= alu_y;
            if (alu_cwr)     carry_o <= alu_cout;
          end else if (opcode == OPC_FLAG_SET) begin
            if (instr_q[BIT_CARRY])  carry_o  <= 1'b1;
            if (instr_q[BIT_TARGET]) target_o <= 1'b1;
            if (instr_q[BIT_ACK])    ack_o    <= 1'b1;
            if (instr_q[BIT_ATN])    atn_o    <= 1'b1;
          end else if (opcode == OPC_FLAG_CLR) begin
            if (instr_q[BIT_CARRY])  carry_o  <= 1'b0;
            if (instr_q[BIT_TARGET]) target_o <= 1'b0;
            if (instr_q[BIT_ACK])    ack_o    <= 1'b0;
            if (instr_q[BIT_ATN])    atn_o    <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scr_regop_chk.sv
module scr_regop_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              done_o,
  input logic [DATA_W-1:0] pivot_o,
  input logic              carry_o,
  input logic              target_o,
  input logic              ack_o,
  input logic              atn_o
);
  logic [1:0] ck;

  always_ff @(posedge clk) begin
    if (rst) ck <= 2'd0;
    else begin
      unique case (ck)
        2'd0:    if (start_i) ck <= 2'd1;
        2'd1:    ck <= 2'd2;
        default: ck <= 2'd0;
      endcase
    end
  end

  a_r2_done_on_time: assert property (@(posedge clk) disable iff (rst)
    (ck == 2'd2) |=> done_o);
  a_r2_done_only_then: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(ck) == 2'd2));
  a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r3_busy_quiet: assert property (@(posedge clk) disable iff (rst)
    (ck == 2'd1) |=> !done_o);
  a_r5_pivot_hold: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(pivot_o));
  a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable({carry_o, target_o, ack_o, atn_o}));
endmodule

bind scr_regop_unit scr_regop_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .done_o   (done_o),
  .pivot_o  (pivot_o),
  .carry_o  (carry_o),
  .target_o (target_o),
  .ack_o    (ack_o),
  .atn_o    (atn_o)
);

// File: tb/scr_regop_unit_tb.sv
module scr_regop_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [6:0]  rd_addr_i = '0;
  logic [7:0]  rd_data_o, pivot_o;
  logic        done_o, carry_o, target_o, ack_o, atn_o;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scr_regop_unit u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .instr_i(instr_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .done_o(done_o),
    .pivot_o(pivot_o), .carry_o(carry_o), .target_o(target_o),
    .ack_o(ack_o), .atn_o(atn_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] form, input logic [2:0] op,
                                     input logic usep, input logic [6:0] a, input logic [7:0] imm);
    return {form, op, usep, a, imm, 8'h00};
  endfunction

  task automatic exec(input logic [31:0] ins);
    @(negedge clk); start_i = 1'b1; instr_i = ins;
    @(negedge clk); start_i = 1'b0; chk("R2 busy1", done_o, 0);
    @(negedge clk); chk("R2 busy2", done_o, 0);
    @(negedge clk); chk("R2 done", done_o, 1);
    @(negedge clk); chk("R2 single", done_o, 0);
  endtask

  task automatic rdreg(input string req, input logic [6:0] a, input logic [7:0] exp);
    @(negedge clk); rd_addr_i = a;
    @(negedge clk); chk(req, rd_data_o, exp);
  endtask

  function automatic logic [3:0] flags();
    return {carry_o, target_o, ack_o, atn_o};
  endfunction

  task automatic t_reset();
    chk("R1 pivot", pivot_o, 0);
    chk("R1 flags", flags(), 0);
    chk("R1 done", done_o, 0);
  endtask

  task automatic t_reg_reg();
    exec(mk(5'b01111, 3'd0, 0, 7'd5, 8'h3C)); rdreg("R4 load", 7'd5, 8'h3C);
    exec(mk(5'b01111, 3'd2, 0, 7'd5, 8'hC3)); rdreg("R4 or", 7'd5, 8'hFF);
    exec(mk(5'b01111, 3'd3, 0, 7'd5, 8'h0F)); rdreg("R4 xor", 7'd5, 8'hF0);
    exec(mk(5'b01111, 3'd4, 0, 7'd5, 8'h3C)); rdreg("R4 and", 7'd5, 8'h30);
    exec(mk(5'b01111, 3'd0, 0, 7'd127, 8'hA5)); rdreg("R4 top addr", 7'd127, 8'hA5);
  endtask

  task automatic t_to_pivot();
    exec(mk(5'b01110, 3'd3, 0, 7'd5, 8'hFF));
    chk("R5 pivot", pivot_o, 8'hCF);
    rdreg("R5 file kept", 7'd5, 8'h30);
  endtask

  task automatic t_from_pivot();
    exec(mk(5'b01101, 3'd4, 0, 7'd7, 8'hF0)); rdreg("R6 reg7", 7'd7, 8'hC0);
    chk("R6 pivot kept", pivot_o, 8'hCF);
  endtask

  task automatic t_pivot_operand();
    exec(mk(5'b01111, 3'd2, 1, 7'd5, 8'h01)); rdreg("R7 or pivot", 7'd5, 8'hFF);
  endtask

  task automatic t_shift();
    exec(mk(5'b01111, 3'd0, 0, 7'd9, 8'h81));
    exec(mk(5'b01111, 3'd1, 0, 7'd9, 8'h00));
    rdreg("R8 shl val", 7'd9, 8'h02); chk("R8 shl carry", carry_o, 1);
    exec(mk(5'b01111, 3'd5, 0, 7'd9, 8'h00));
    rdreg("R8 shr val", 7'd9, 8'h01); chk("R8 shr carry", carry_o, 0);
    exec(mk(5'b01111, 3'd5, 0, 7'd9, 8'h00));
    rdreg("R8 shr out", 7'd9, 8'h00); chk("R8 shr carry1", carry_o, 1);
  endtask

  task automatic t_add();
    exec(32'h6000_0400);
    exec(mk(5'b01111, 3'd0, 0, 7'd10, 8'hF0));
    exec(mk(5'b01111, 3'd6, 0, 7'd10, 8'h20));
    rdreg("R9 add", 7'd10, 8'h10); chk("R9 add carry", carry_o, 1);
    exec(mk(5'b01111, 3'd7, 0, 7'd10, 8'h01));
    rdreg("R9 addc", 7'd10, 8'h12); chk("R9 addc carry", carry_o, 0);
    exec(32'h5800_0400);
    exec(mk(5'b01111, 3'd2, 0, 7'd10, 8'h01));
    rdreg("R9 or", 7'd10, 8'h13); chk("R9 or keeps carry", carry_o, 1);
  endtask

  task automatic t_flags();
    exec(32'h6000_0648); chk("R10 clr all", flags(), 4'b0000);
    exec(32'h5800_0648); chk("R10 set all", flags(), 4'b1111);
    exec(32'h6000_0040); chk("R10 clr ack", flags(), 4'b1101);
    exec(32'h6000_01B7); chk("R10 other bits", flags(), 4'b1101);
    exec(32'h6000_0608); chk("R10 clr rest", flags(), 4'b0000);
    exec(32'h5800_0008); chk("R10 set atn", flags(), 4'b0001);
  endtask

  task automatic t_busy();
    @(negedge clk); start_i = 1'b1; instr_i = mk(5'b01111, 3'd0, 0, 7'd12, 8'h55);
    @(negedge clk); instr_i = mk(5'b01111, 3'd0, 0, 7'd12, 8'hAA);
    @(negedge clk); start_i = 1'b0; chk("R3 busy", done_o, 0);
    @(negedge clk); chk("R3 done", done_o, 1);
    @(negedge clk); chk("R3 no second", done_o, 0);
    @(negedge clk); chk("R3 no second b", done_o, 0);
    @(negedge clk); chk("R3 no second c", done_o, 0);
    rdreg("R3 first wins", 7'd12, 8'h55);
  endtask

  task automatic t_other();
    exec(32'h8008_0500);
    chk("R11 pivot", pivot_o, 8'hCF);
    chk("R11 flags", flags(), 4'b0001);
    rdreg("R11 file", 7'd5, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_reg_reg();
    t_to_pivot();
    t_from_pivot();
    t_pivot_operand();
    t_shift();
    t_add();
    t_flags();
    t_busy();
    t_other();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule